// File: doc/BRIEF.md
# Two-Fan Speed Arbitration Controller

This block chooses a 4-bit duty code for each of two fans and turns each code into a pulse-width waveform. Its inputs are a small register file, written and read through a plain synchronous port, and a set of event flags. The flags come from fault monitors, fan-presence detectors, general-purpose inputs, temperature comparators, analog-limit comparators, a shared active-low fault line, and a sleep/thermal-override pair. Per-fan mask bits decide which events may act on which fan. A fault seen on either fan can be routed to both fans.

Each fan has four candidate codes. Full speed wins outright. A hot-plug request competes with an alarm request, and a per-fan priority bit decides which of the two wins. With no request active, the fan runs at its minimum code. Under software control the minimum code is the programmed minimum/alarm code. Otherwise it is a code supplied from outside by a temperature-slope controller. The waveform period is 15 slots long, and the slot length is set per fan. A new code is applied only when a period begins.

Top module: `fan_speed_arbiter`

## Requirements
- R1: After reset every minimum/alarm code and every hot-plug code reads 0xF, both duty outputs are 0xF, and both PWM outputs are high.
- R2: Register map (6-bit address, 8-bit data). Writes take effect at the next clock edge. Reads are combinational.
  - 0x00/0x01: fan configuration. [3:0] hot-plug code, [5:4] frequency select, [7:6] pulses per revolution.
  - 0x02: hot-plug force. Bit f is fan f.
  - 0x03: full-speed force. Bit f is fan f.
  - 0x04/0x05: priority. Bit 5 only.
  - 0x06/0x07: minimum/alarm code. [3:0].
  - 0x08/0x09: fault-line action. Bit 6 only.
  - 0x0A/0x0B: fault/removal routing mask for the fault on fan 0 / fan 1.
  - 0x10+g: GPIO behaviour. Bit 0 = input, bit 1 = active-high level, bit 5 = hot-plug enable.
  - 0x18+g: GPIO mask.
  - 0x20+t: temperature action mask.
  - 0x28+a: analog mask.
  - In every mask, bit 0 targets fan 0 and bit 1 targets fan 1.
  - Unstored bits and unmapped addresses read 0.
- R3: A set full-speed bit makes that fan's duty 0xF, whatever else is requested.
- R4: A fan receives a hot-plug request from any of three sources:
  - its force bit;
  - the removal of the other fan, when the removed fan's routing mask bit for this fan is set (a fan's own removal never requests hot-plug for itself);
  - the fault line held low, when its fault-line action bit 6 is set.
- R5: A GPIO requests hot-plug for the fans enabled in its mask only while three conditions hold: bit 0 is set, bit 5 is set, and the pin level equals bit 1.
- R6: A fan receives an alarm request from a flagged fault on either fan, a temperature flag or an analog flag, each only through its mask bit for that fan. The alarm code is the minimum/alarm code.
- R7: Sleep and thermal override asserted together request alarm for both fans, with no mask applied.
- R8: When hot-plug and alarm are both requested, the hot-plug code wins if the fan's priority bit 5 is set, and the alarm code wins otherwise.
- R9: With no request, a fan uses its minimum/alarm code when bits 1:0 of every temperature action register are zero. Otherwise it uses its external automatic code.
- R10: Code N drives the PWM output high for N of the 15 slots of each period. Code 0 gives constant low and code 0xF gives constant high.
- R11: Frequency select s sets the slot length to SLOT_BASE·2^s clock cycles.
- R12: A new duty code or frequency select is applied only at the start of a PWM period, so no period is cut short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 6 | Register address for read and write |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| fan_fault_i | input | 2 | Fault flag per fan (underspeed or fault input) |
| fan_absent_i | input | 2 | Fan removed flag per fan |
| ext_fault_ni | input | 1 | Shared fault line, active low |
| gpio_i | input | NGPIO | General-purpose input levels |
| temp_fault_i | input | NTEMP | Temperature fault flags |
| ain_event_i | input | NAIN | Analog-limit event flags |
| sleep_i | input | 1 | Device in sleep |
| therm_ovr_i | input | 1 | Thermal override |
| auto_code_i | input | 8 | External automatic codes, fan f at [4f+3:4f] |
| duty_o | output | 8 | Selected duty code, fan f at [4f+3:4f] |
| pwm_o | output | 2 | PWM output per fan |

## Verification
A wrong request or priority decision shows on duty_o in the same cycle that the input or register settles. The bench therefore checks every routing and mask case one cycle after stimulus. A corrupted slot counter, prescaler or latched code shows only on pwm_o, and only over a whole period: up to 120 cycles at the slowest setting. For this reason high-time totals and longest high runs are measured over two periods. A boundary fault is caught by changing the code in mid-period and timing the high run that follows.

// File: rtl/fsa_pkg.sv
package fsa_pkg;
   localparam int NFAN      = 2;
   localparam int CODE_W    = 4;
   localparam int NSLOT     = 15;
   localparam logic [CODE_W-1:0] CODE_FULL = 4'hF;

   // register map base addresses
   localparam int A_CFG     = 'h00;
   localparam int A_HPFORCE = 'h02;
   localparam int A_FULL    = 'h03;
   localparam int A_PRIO    = 'h04;
   localparam int A_MINALM  = 'h06;
   localparam int A_LINEACT = 'h08;
   localparam int A_FANMASK = 'h0A;
   localparam int A_GPBEH   = 'h10;
   localparam int A_GPMASK  = 'h18;
   localparam int A_TMPACT  = 'h20;
   localparam int A_AINMASK = 'h28;
   localparam int BANK_MAX  = 8;

   typedef logic [CODE_W-1:0]   code_t;
   typedef logic [NFAN-1:0]     fanvec_t;
endpackage

// File: rtl/fsa_regs.sv
module fsa_regs
   import fsa_pkg::*;
#(
   parameter int NGPIO = 2,
   parameter int NTEMP = 3,
   parameter int NAIN  = 2,
   parameter int AW    = 6
) (
   input  logic                        clk_i,
   input  logic                        rst_ni,
   input  logic                        wr_en_i,
   input  logic [AW-1:0]               addr_i,
   input  logic [7:0]                  wdata_i,
   output logic [7:0]                  rdata_o,
   output code_t  [NFAN-1:0]           hp_code_o,
   output logic   [NFAN-1:0][1:0]      fsel_o,
   output fanvec_t                     force_hp_o,
   output fanvec_t                     force_full_o,
   output fanvec_t                     hp_first_o,
   output code_t  [NFAN-1:0]           minalm_o,
   output fanvec_t                     line_act_o,
   output fanvec_t [NFAN-1:0]          fan_mask_o,
   output logic   [NGPIO-1:0]          gp_in_o,
   output logic   [NGPIO-1:0]          gp_pol_o,
   output logic   [NGPIO-1:0]          gp_hpen_o,
   output fanvec_t [NGPIO-1:0]         gp_mask_o,
   output fanvec_t [NTEMP-1:0]         tmp_act_o,
   output fanvec_t [NAIN-1:0]          ain_mask_o
);
   logic [NFAN-1:0][7:0] cfg_q;
   fanvec_t              hpf_q, full_q, prio_q, line_q;
   code_t  [NFAN-1:0]    minalm_q;
   fanvec_t [NFAN-1:0]   fmask_q;
   logic [NGPIO-1:0]     gin_q, gpol_q, ghp_q;
   fanvec_t [NGPIO-1:0]  gmask_q;
   fanvec_t [NTEMP-1:0]  tact_q;
   fanvec_t [NAIN-1:0]   amask_q;

   function automatic logic hit(input logic [AW-1:0] a, input int base, input int idx);
      return a == AW'(base + idx);
   endfunction

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cfg_q    <= '{default: 8'h0F};
         hpf_q    <= '0;
         full_q   <= '0;
         prio_q   <= '0;
         line_q   <= '0;
         minalm_q <= '{default: CODE_FULL};
         fmask_q  <= '0;
         gin_q    <= '0;
         gpol_q   <= '0;
         ghp_q    <= '0;
         gmask_q  <= '0;
         tact_q   <= '0;
         amask_q  <= '0;
      end else if (wr_en_i) begin
         if (hit(addr_i, A_HPFORCE, 0)) hpf_q  <= wdata_i[NFAN-1:0];
         if (hit(addr_i, A_FULL, 0))    full_q <= wdata_i[NFAN-1:0];
         for (int f = 0; f < NFAN; f++) begin
            if (hit(addr_i, A_CFG, f))     cfg_q[f]    <= wdata_i;
            if (hit(addr_i, A_PRIO, f))    prio_q[f]   <= wdata_i[5];
            if (hit(addr_i, A_MINALM, f))  minalm_q[f] <= wdata_i[CODE_W-1:0];
            if (hit(addr_i, A_LINEACT, f)) line_q[f]   <= wdata_i[6];
            if (hit(addr_i, A_FANMASK, f)) fmask_q[f]  <= wdata_i[NFAN-1:0];
         end
         for (int g = 0; g < NGPIO; g++) begin
            if (hit(addr_i, A_GPBEH, g)) begin
               gin_q[g]  <= wdata_i[0];
               gpol_q[g] <= wdata_i[1];
               ghp_q[g]  <= wdata_i[5];
            end
            if (hit(addr_i, A_GPMASK, g)) gmask_q[g] <= wdata_i[NFAN-1:0];
         end
         for (int t = 0; t < NTEMP; t++)
            if (hit(addr_i, A_TMPACT, t)) tact_q[t] <= wdata_i[NFAN-1:0];
         for (int a = 0; a < NAIN; a++)
            if (hit(addr_i, A_AINMASK, a)) amask_q[a] <= wdata_i[NFAN-1:0];
      end
   end

   always_comb begin
      rdata_o = '0;
      if (hit(addr_i, A_HPFORCE, 0)) rdata_o = 8'(hpf_q);
      if (hit(addr_i, A_FULL, 0))    rdata_o = 8'(full_q);
      for (int f = 0; f < NFAN; f++) begin
         if (hit(addr_i, A_CFG, f))     rdata_o = cfg_q[f];
         if (hit(addr_i, A_PRIO, f))    rdata_o = {2'b0, prio_q[f], 5'b0};
         if (hit(addr_i, A_MINALM, f))  rdata_o = 8'(minalm_q[f]);
         if (hit(addr_i, A_LINEACT, f)) rdata_o = {1'b0, line_q[f], 6'b0};
         if (hit(addr_i, A_FANMASK, f)) rdata_o = 8'(fmask_q[f]);
      end
      for (int g = 0; g < NGPIO; g++) begin
         if (hit(addr_i, A_GPBEH, g))  rdata_o = {2'b0, ghp_q[g], 3'b0, gpol_q[g], gin_q[g]};
         if (hit(addr_i, A_GPMASK, g)) rdata_o = 8'(gmask_q[g]);
      end
      for (int t = 0; t < NTEMP; t++)
         if (hit(addr_i, A_TMPACT, t)) rdata_o = 8'(tact_q[t]);
      for (int a = 0; a < NAIN; a++)
         if (hit(addr_i, A_AINMASK, a)) rdata_o = 8'(amask_q[a]);
   end

   for (genvar f = 0; f < NFAN; f++) begin : g_fan_out
      assign hp_code_o[f] = cfg_q[f][3:0];
      assign fsel_o[f]    = cfg_q[f][5:4];
   end

   assign force_hp_o   = hpf_q;
   assign force_full_o = full_q;
   assign hp_first_o   = prio_q;
   assign minalm_o     = minalm_q;
   assign line_act_o   = line_q;
   assign fan_mask_o   = fmask_q;
   assign gp_in_o      = gin_q;
   assign gp_pol_o     = gpol_q;
   assign gp_hpen_o    = ghp_q;
   assign gp_mask_o    = gmask_q;
   assign tmp_act_o    = tact_q;
   assign ain_mask_o   = amask_q;
endmodule

// File: rtl/fsa_events.sv
module fsa_events
   import fsa_pkg::*;
#(
   parameter int NGPIO = 2,
   parameter int NTEMP = 3,
   parameter int NAIN  = 2
) (
   input  fanvec_t                 fan_fault_i,
   input  fanvec_t                 fan_absent_i,
   input  logic                    ext_fault_ni,
   input  logic [NGPIO-1:0]        gpio_i,
   input  logic [NTEMP-1:0]        temp_fault_i,
   input  logic [NAIN-1:0]         ain_event_i,
   input  logic                    sleep_i,
   input  logic                    therm_ovr_i,
   input  fanvec_t                 force_hp_i,
   input  fanvec_t                 line_act_i,
   input  fanvec_t [NFAN-1:0]      fan_mask_i,
   input  logic [NGPIO-1:0]        gp_in_i,
   input  logic [NGPIO-1:0]        gp_pol_i,
   input  logic [NGPIO-1:0]        gp_hpen_i,
   input  fanvec_t [NGPIO-1:0]     gp_mask_i,
   input  fanvec_t [NTEMP-1:0]     tmp_act_i,
   input  fanvec_t [NAIN-1:0]      ain_mask_i,
   output fanvec_t                 hp_req_o,
   output fanvec_t                 alm_req_o
);
   logic [NGPIO-1:0] gp_live;
   logic             line_low;
   logic             sleep_ovr;

   assign line_low  = ~ext_fault_ni;
   assign sleep_ovr = sleep_i & therm_ovr_i;

   for (genvar g = 0; g < NGPIO; g++) begin : g_gpio
      assign gp_live[g] = gp_in_i[g] & gp_hpen_i[g] & (gpio_i[g] == gp_pol_i[g]);
   end

   for (genvar f = 0; f < NFAN; f++) begin : g_fan
      logic hp_l, alm_l;
      always_comb begin
         hp_l  = force_hp_i[f] | (line_act_i[f] & line_low);
         alm_l = sleep_ovr;
         for (int j = 0; j < NFAN; j++) begin
            alm_l = alm_l | (fan_fault_i[j] & fan_mask_i[j][f]);
            if (j != f)
               hp_l = hp_l | (fan_absent_i[j] & fan_mask_i[j][f]);
         end
         for (int g = 0; g < NGPIO; g++)
            hp_l = hp_l | (gp_live[g] & gp_mask_i[g][f]);
         for (int t = 0; t < NTEMP; t++)
            alm_l = alm_l | (temp_fault_i[t] & tmp_act_i[t][f]);
         for (int a = 0; a < NAIN; a++)
            alm_l = alm_l | (ain_event_i[a] & ain_mask_i[a][f]);
      end
      assign hp_req_o[f]  = hp_l;
      assign alm_req_o[f] = alm_l;
   end
endmodule

// File: rtl/fsa_duty_sel.sv
module fsa_duty_sel
   import fsa_pkg::*;
(
   input  logic  full_i,
   input  logic  hp_req_i,
   input  logic  alm_req_i,
   input  logic  hp_first_i,
   input  code_t hp_code_i,
   input  code_t alm_code_i,
   input  code_t base_code_i,
   output code_t duty_o
);
   always_comb begin
      if (full_i)
         duty_o = CODE_FULL;
      else if (hp_req_i && alm_req_i)
         duty_o = hp_first_i ? hp_code_i : alm_code_i;
      else if (hp_req_i)
         duty_o = hp_code_i;
      else if (alm_req_i)
         duty_o = alm_code_i;
      else
         duty_o = base_code_i;
   end
endmodule

// File: rtl/fsa_pwm.sv
module fsa_pwm
   import fsa_pkg::*;
#(
   parameter int SLOT_BASE = 1,
   parameter bit OUT_REG   = 1'b0
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  code_t      code_i,
   input  logic [1:0] fsel_i,
   output logic       pwm_o,
   output code_t      code_act_o,
   output logic       period_start_o
);
   localparam int MAX_LEN = SLOT_BASE << 3;
   localparam int PRE_W   = $clog2(MAX_LEN + 1);
   localparam logic [3:0] LAST_SLOT = 4'(NSLOT - 1);

   if (SLOT_BASE < 1) begin : g_bad_base
      $error("fsa_pwm: SLOT_BASE must be at least 1");
   end

   logic [PRE_W-1:0] pre_q, slot_len;
   logic [3:0]       slot_q;
   code_t            code_q;
   logic [1:0]       fsel_q;
   logic             tick_last, raw;

   assign slot_len  = PRE_W'(SLOT_BASE) << fsel_q;
   assign tick_last = (pre_q == slot_len - PRE_W'(1));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pre_q  <= '0;
         slot_q <= '0;
         code_q <= CODE_FULL;
         fsel_q <= '0;
      end else if (tick_last) begin
         pre_q <= '0;
         if (slot_q == LAST_SLOT) begin
            slot_q <= '0;
            code_q <= code_i;
            fsel_q <= fsel_i;
         end else begin
            slot_q <= slot_q + 4'd1;
         end
      end else begin
         pre_q <= pre_q + PRE_W'(1);
      end
   end

   assign raw = (slot_q < code_q);

   if (OUT_REG) begin : g_out_reg
      logic pwm_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) pwm_q <= 1'b1;
         else         pwm_q <= raw;
      end
      assign pwm_o = pwm_q;
   end else begin : g_out_comb
      assign pwm_o = raw;
   end

   assign code_act_o     = code_q;
   assign period_start_o = (slot_q == 4'd0) && (pre_q == '0);
endmodule

// File: rtl/fan_speed_arbiter.sv
module fan_speed_arbiter
   import fsa_pkg::*;
#(
   parameter int NGPIO     = 2,
   parameter int NTEMP     = 3,
   parameter int NAIN      = 2,
   parameter int SLOT_BASE = 1,
   parameter bit OUT_REG   = 1'b0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             wr_en_i,
   input  logic [5:0]       addr_i,
   input  logic [7:0]       wdata_i,
   output logic [7:0]       rdata_o,
   input  logic [1:0]       fan_fault_i,
   input  logic [1:0]       fan_absent_i,
   input  logic             ext_fault_ni,
   input  logic [NGPIO-1:0] gpio_i,
   input  logic [NTEMP-1:0] temp_fault_i,
   input  logic [NAIN-1:0]  ain_event_i,
   input  logic             sleep_i,
   input  logic             therm_ovr_i,
   input  logic [7:0]       auto_code_i,
   output logic [7:0]       duty_o,
   output logic [1:0]       pwm_o
);
   localparam int AW = 6;

   if (NGPIO < 1 || NGPIO > BANK_MAX) begin : g_bad_gpio
      $error("fan_speed_arbiter: NGPIO out of range");
   end
   if (NTEMP < 1 || NTEMP > BANK_MAX) begin : g_bad_temp
      $error("fan_speed_arbiter: NTEMP out of range");
   end
   if (NAIN < 1 || NAIN > BANK_MAX) begin : g_bad_ain
      $error("fan_speed_arbiter: NAIN out of range");
   end

   code_t  [NFAN-1:0]      hp_code, minalm, duty, code_act, auto_code;
   logic   [NFAN-1:0][1:0] fsel;
   fanvec_t                force_hp, force_full, hp_first, line_act;
   fanvec_t [NFAN-1:0]     fan_mask;
   logic [NGPIO-1:0]       gp_in, gp_pol, gp_hpen;
   fanvec_t [NGPIO-1:0]    gp_mask;
   fanvec_t [NTEMP-1:0]    tmp_act;
   fanvec_t [NAIN-1:0]     ain_mask;
   fanvec_t                hp_req, alm_req, period_start;
   logic                   sw_mode;

   assign auto_code = auto_code_i;

   fsa_regs #(.NGPIO(NGPIO), .NTEMP(NTEMP), .NAIN(NAIN), .AW(AW)) u_regs (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_en_i     (wr_en_i),
      .addr_i      (addr_i),
      .wdata_i     (wdata_i),
      .rdata_o     (rdata_o),
      .hp_code_o   (hp_code),
      .fsel_o      (fsel),
      .force_hp_o  (force_hp),
      .force_full_o(force_full),
      .hp_first_o  (hp_first),
      .minalm_o    (minalm),
      .line_act_o  (line_act),
      .fan_mask_o  (fan_mask),
      .gp_in_o     (gp_in),
      .gp_pol_o    (gp_pol),
      .gp_hpen_o   (gp_hpen),
      .gp_mask_o   (gp_mask),
      .tmp_act_o   (tmp_act),
      .ain_mask_o  (ain_mask)
   );

   fsa_events #(.NGPIO(NGPIO), .NTEMP(NTEMP), .NAIN(NAIN)) u_events (
      .fan_fault_i (fan_fault_i),
      .fan_absent_i(fan_absent_i),
      .ext_fault_ni(ext_fault_ni),
      .gpio_i      (gpio_i),
      .temp_fault_i(temp_fault_i),
      .ain_event_i (ain_event_i),
      .sleep_i     (sleep_i),
      .therm_ovr_i (therm_ovr_i),
      .force_hp_i  (force_hp),
      .line_act_i  (line_act),
      .fan_mask_i  (fan_mask),
      .gp_in_i     (gp_in),
      .gp_pol_i    (gp_pol),
      .gp_hpen_i   (gp_hpen),
      .gp_mask_i   (gp_mask),
      .tmp_act_i   (tmp_act),
      .ain_mask_i  (ain_mask),
      .hp_req_o    (hp_req),
      .alm_req_o   (alm_req)
   );

   // software control when no temperature channel claims any fan
   always_comb begin
      sw_mode = 1'b1;
      for (int t = 0; t < NTEMP; t++)
         if (tmp_act[t] != '0) sw_mode = 1'b0;
   end

   for (genvar f = 0; f < NFAN; f++) begin : g_fan
      code_t base_code;
      assign base_code = sw_mode ? minalm[f] : auto_code[f];

      fsa_duty_sel u_sel (
         .full_i     (force_full[f]),
         .hp_req_i   (hp_req[f]),
         .alm_req_i  (alm_req[f]),
         .hp_first_i (hp_first[f]),
         .hp_code_i  (hp_code[f]),
         .alm_code_i (minalm[f]),
         .base_code_i(base_code),
         .duty_o     (duty[f])
      );

      fsa_pwm #(.SLOT_BASE(SLOT_BASE), .OUT_REG(OUT_REG)) u_pwm (
         .clk_i         (clk_i),
         .rst_ni        (rst_ni),
         .code_i        (duty[f]),
         .fsel_i        (fsel[f]),
         .pwm_o         (pwm_o[f]),
         .code_act_o    (code_act[f]),
         .period_start_o(period_start[f])
      );
   end

   assign duty_o = duty;
endmodule

// File: rtl/fsa_checker.sv
module fsa_checker
   import fsa_pkg::*;
(
   input logic              clk_i,
   input logic              rst_ni,
   input fanvec_t           force_full,
   input fanvec_t           force_hp,
   input fanvec_t           hp_req,
   input fanvec_t           alm_req,
   input fanvec_t           hp_first,
   input code_t [NFAN-1:0]  hp_code,
   input code_t [NFAN-1:0]  minalm,
   input code_t [NFAN-1:0]  duty,
   input code_t [NFAN-1:0]  code_act,
   input fanvec_t           period_start,
   input logic              sleep_i,
   input logic              therm_ovr_i
);
   for (genvar f = 0; f < NFAN; f++) begin : g_chk
      assert_full_speed_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
         force_full[f] |-> duty[f] == CODE_FULL);

      assert_force_hp_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
         force_hp[f] |-> hp_req[f]);

      assert_sleep_alarm_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (sleep_i && therm_ovr_i) |-> alm_req[f]);

      assert_hp_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (hp_req[f] && alm_req[f] && !force_full[f] && hp_first[f]) |-> duty[f] == hp_code[f]);

      assert_alarm_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (hp_req[f] && alm_req[f] && !force_full[f] && !hp_first[f]) |-> duty[f] == minalm[f]);

      assert_code_boundary_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !$stable(code_act[f]) |-> period_start[f]);
   end
endmodule

bind fan_speed_arbiter fsa_checker u_fsa_checker (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .force_full  (force_full),
   .force_hp    (force_hp),
   .hp_req      (hp_req),
   .alm_req     (alm_req),
   .hp_first    (hp_first),
   .hp_code     (hp_code),
   .minalm      (minalm),
   .duty        (duty),
   .code_act    (code_act),
   .period_start(period_start),
   .sleep_i     (sleep_i),
   .therm_ovr_i (therm_ovr_i)
);

// File: tb/tb_fan_speed_arbiter.sv
module tb_fan_speed_arbiter;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [5:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic [1:0] fan_fault = '0, fan_absent = '0;
   logic       ext_fault_n = 1'b1;
   logic [1:0] gpio = '0;
   logic [2:0] temp_fault = '0;
   logic [1:0] ain_event = '0;
   logic       sleep = 1'b0, therm = 1'b0;
   logic [7:0] auto_code = 8'h98;
   logic [7:0] duty;
   logic [1:0] pwm;

   int checks = 0;
   int failures = 0;

   always #2.5 clk = ~clk;

   fan_speed_arbiter dut (
      .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
      .rdata_o(rdata), .fan_fault_i(fan_fault), .fan_absent_i(fan_absent),
      .ext_fault_ni(ext_fault_n), .gpio_i(gpio), .temp_fault_i(temp_fault),
      .ain_event_i(ain_event), .sleep_i(sleep), .therm_ovr_i(therm),
      .auto_code_i(auto_code), .duty_o(duty), .pwm_o(pwm)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_check(input string req, input logic [5:0] a, input logic [7:0] exp);
      @(negedge clk);
      addr = a;
      #1;
      check(req, int'(rdata), int'(exp));
   endtask

   task automatic duty_check(input string req, input logic [7:0] exp);
      @(negedge clk);
      check(req, int'(duty), int'(exp));
   endtask

   task automatic measure(input int cycles, output int total, output int maxrun);
      int run = 0;
      total = 0; maxrun = 0;
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         if (pwm[0]) begin
            total++; run++;
            if (run > maxrun) maxrun = run;
         end else run = 0;
      end
   endtask

   task automatic t_reset();
      @(negedge clk);
      check("R1 duty", int'(duty), 'hFF);
      check("R1 pwm", int'(pwm), 'h3);
      rd_check("R1 minalm0", 6'h06, 8'h0F);
      rd_check("R1 cfg1", 6'h01, 8'h0F);
   endtask

   task automatic t_regs();
      wr(6'h00, 8'hA5); rd_check("R2 cfg0", 6'h00, 8'hA5);
      wr(6'h04, 8'hFF); rd_check("R2 prio", 6'h04, 8'h20);
      wr(6'h08, 8'hFF); rd_check("R2 lineact", 6'h08, 8'h40);
      wr(6'h10, 8'hFF); rd_check("R2 gpbeh", 6'h10, 8'h23);
      wr(6'h22, 8'hFF); rd_check("R2 tmpact", 6'h22, 8'h03);
      rd_check("R2 unmapped", 6'h3F, 8'h00);
      wr(6'h04, 8'h00); wr(6'h08, 8'h00); wr(6'h10, 8'h00); wr(6'h22, 8'h00);
      wr(6'h00, 8'h02); wr(6'h01, 8'h04); wr(6'h06, 8'h03); wr(6'h07, 8'h03);
      duty_check("R9 sw base", 8'h33);
   endtask

   task automatic t_full();
      wr(6'h03, 8'h01); duty_check("R3 fan0 full", 8'h3F);
      wr(6'h02, 8'h02); wr(6'h03, 8'h03); duty_check("R3 full over hp", 8'hFF);
      wr(6'h03, 8'h00); wr(6'h02, 8'h00); duty_check("R3 cleared", 8'h33);
   endtask

   task automatic t_hp();
      wr(6'h02, 8'h02); duty_check("R4 force fan1", 8'h43);
      wr(6'h02, 8'h00);
      fan_absent = 2'b01; duty_check("R4 removal masked", 8'h33);
      wr(6'h0A, 8'h03); duty_check("R4 removal to other fan only", 8'h43);
      fan_absent = 2'b00; wr(6'h0A, 8'h00);
      ext_fault_n = 1'b0; duty_check("R4 line without action bit", 8'h33);
      wr(6'h09, 8'h40); duty_check("R4 line low", 8'h43);
      ext_fault_n = 1'b1; duty_check("R4 line released", 8'h33);
      wr(6'h09, 8'h00);
   endtask

   task automatic t_gpio();
      wr(6'h10, 8'h23); wr(6'h18, 8'h03);
      duty_check("R5 inactive level", 8'h33);
      gpio = 2'b01; duty_check("R5 active high", 8'h42);
      wr(6'h10, 8'h03); duty_check("R5 no hp enable", 8'h33);
      wr(6'h10, 8'h22); duty_check("R5 not input", 8'h33);
      wr(6'h10, 8'h21); gpio = 2'b00; duty_check("R5 active low", 8'h42);
      wr(6'h18, 8'h01); duty_check("R5 mask fan0 only", 8'h32);
      wr(6'h10, 8'h00); wr(6'h18, 8'h00);
   endtask

   task automatic t_alarm();
      wr(6'h20, 8'h01); duty_check("R9 auto base", 8'h98);
      temp_fault = 3'b001; duty_check("R6 temp alarm fan0", 8'h93);
      temp_fault = 3'b000;
      fan_fault = 2'b10; wr(6'h0B, 8'h01); duty_check("R6 fan1 fault to fan0", 8'h93);
      wr(6'h0B, 8'h02); duty_check("R6 fan1 fault to fan1", 8'h38);
      wr(6'h0B, 8'h00); duty_check("R6 fault masked", 8'h98);
      fan_fault = 2'b00;
      ain_event = 2'b10; wr(6'h29, 8'h03); duty_check("R6 analog both", 8'h33);
      ain_event = 2'b00; wr(6'h29, 8'h00);
      wr(6'h20, 8'h00); duty_check("R9 back to sw", 8'h33);
      wr(6'h20, 8'h01);
   endtask

   task automatic t_sleep();
      sleep = 1'b1; duty_check("R7 sleep alone", 8'h98);
      therm = 1'b1; duty_check("R7 sleep override", 8'h33);
      sleep = 1'b0; duty_check("R7 override alone", 8'h98);
      therm = 1'b0;
   endtask

   task automatic t_prio();
      sleep = 1'b1; therm = 1'b1;
      wr(6'h02, 8'h01); duty_check("R8 alarm wins", 8'h33);
      wr(6'h04, 8'h20); duty_check("R8 hp wins fan0", 8'h32);
      wr(6'h02, 8'h03); duty_check("R8 fan1 alarm wins", 8'h32);
      wr(6'h05, 8'h20); duty_check("R8 hp wins fan1", 8'h42);
      wr(6'h02, 8'h00); wr(6'h04, 8'h00); wr(6'h05, 8'h00);
      sleep = 1'b0; therm = 1'b0;
      wr(6'h20, 8'h00);
   endtask

   task automatic t_pwm();
      int tot, run;
      wr(6'h06, 8'h05); repeat (250) @(negedge clk);
      measure(30, tot, run);
      check("R10 code5 total", tot, 10); check("R10 code5 run", run, 5);
      wr(6'h06, 8'h00); repeat (250) @(negedge clk);
      measure(30, tot, run); check("R10 code0 low", tot, 0);
      wr(6'h06, 8'h0F); repeat (250) @(negedge clk);
      measure(30, tot, run); check("R10 codeF high", tot, 30);
      wr(6'h00, 8'h22); wr(6'h06, 8'h05); repeat (300) @(negedge clk);
      measure(120, tot, run);
      check("R11 fsel2 total", tot, 40); check("R11 fsel2 run", run, 20);
      wr(6'h00, 8'h32); repeat (300) @(negedge clk);
      measure(240, tot, run);
      check("R11 fsel3 total", tot, 80); check("R11 fsel3 run", run, 40);
   endtask

   task automatic t_boundary();
      int tot, run, hi;
      logic prev;
      wr(6'h06, 8'h07); repeat (300) @(negedge clk);
      prev = pwm[0];
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         if (!prev && pwm[0]) break;
         prev = pwm[0];
      end
      hi = 1;
      fork
         wr(6'h06, 8'h0F);
         begin
            for (int i = 0; i < 200; i++) begin
               @(negedge clk);
               if (!pwm[0]) break;
               hi++;
            end
         end
      join
      check("R12 period kept old code", hi, 56);
      repeat (70) @(negedge clk);
      measure(120, tot, run); check("R12 new code next period", tot, 120);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_regs();
      t_full();
      t_hp();
      t_gpio();
      t_alarm();
      t_sleep();
      t_prio();
      t_pwm();
      t_boundary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule